// File: doc/BRIEF.md
# Process-tagged address translation buffer

This block keeps a small set of recently used page translations and answers translation lookups from them. Every entry is tagged with the ID of the process that owns it, so translations from several processes can stay in the buffer at the same time and a context switch does not require emptying it. A lookup presents a virtual address, the current process ID and whether the access is a store. One clock later the block reports exactly one result: a hit with the physical address, a write fault when a store reaches a read-only translation, or a miss so that an external table walker can fetch the mapping.

Entries map either a 4 KB page or a 2 MB large page. A large entry compares only the upper page-number bits, and the lower bits of the address pass straight into the physical address. The walker's answer is written in through a refill port. A single translation can be purged for one process, or the whole buffer emptied in one cycle.

The response is produced by a four-state machine. `RS_IDLE` holds when no lookup was made in the previous cycle. `RS_MISS` is entered when a lookup found no entry. `RS_WFAULT` is entered when a store matched a read-only entry. `RS_HIT` is entered for any other matching lookup. Each state can move to any of the four on every clock. The lookup request decides the next state, so the machine never waits in a state.

Top module: `tagged_tlb`

## Requirements
- R1: After reset every entry is invalid and `rs_hit`, `rs_miss`, `rs_wfault` and `rs_paddr` are all zero. A lookup made after reset reports a miss.
- R2: A lookup in cycle N raises exactly one of `rs_hit`, `rs_miss` or `rs_wfault` in cycle N+1. In a cycle after no lookup, all three are low. The lookup sees the buffer contents before any refill or invalidation in the same cycle.
- R3: A lookup hits only when a valid entry matches the page and its stored process ID equals `lk_pid`. The same page under another process ID misses.
- R4: For a 4 KB entry, `rs_paddr` is the stored frame number followed by `lk_vaddr[11:0]`. `rs_paddr` is zero whenever `rs_hit` is low.
- R5: A large entry matches on `lk_vaddr[31:21]` alone. Its physical address is the stored frame bits [19:9] followed by `lk_vaddr[20:0]`, and the low 9 frame bits are ignored.
- R6: A store that matches an entry with `fill_writable` clear raises `rs_wfault` with `rs_hit` low and `rs_paddr` zero. A load to the same entry hits. A store to a writable entry hits.
- R7: A refill first removes every valid entry of the same process that overlaps the new page. Two pages overlap when they are equal, or when either is large and they share bits [31:21]. The refill is written into the lowest-indexed overlapping slot. If there is none, it goes into the lowest invalid slot. Otherwise it goes into the slot named by a round-robin pointer, which starts at 0 and then advances modulo the entry count.
- R8: `inv_one` removes every entry of `inv_pid` whose page covers `inv_vpn`, with a large entry covering all 512 small pages in its range. Other entries are kept.
- R9: `inv_all` makes every entry invalid in one cycle, so a lookup in the next cycle misses.
- R10: When update requests coincide, `inv_all` wins over `inv_one`, and `inv_one` wins over a refill. The losing request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_pid | input | 8 | Current process ID |
| lk_store | input | 1 | Lookup is a store |
| rs_hit | output | 1 | Registered hit |
| rs_miss | output | 1 | Registered miss |
| rs_wfault | output | 1 | Registered write fault |
| rs_paddr | output | 32 | Registered physical address |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_pid | input | 8 | Refill process ID |
| fill_pfn | input | 20 | Refill frame number |
| fill_large | input | 1 | Refill is a 2 MB page |
| fill_writable | input | 1 | Refill permits stores |
| inv_one | input | 1 | Purge the translation of one page |
| inv_vpn | input | 20 | Page to purge |
| inv_pid | input | 8 | Process of the page to purge |
| inv_all | input | 1 | Empty the whole buffer |

## Verification
A wrong valid bit or a stale tag appears at the ports as a hit where a miss was expected, or the reverse, one cycle after the next lookup of the affected page. A victim pointer that has drifted shows only when a later lookup finds that a different translation was evicted. For that reason the random phase fills the buffer far past its capacity using a small pool of pages and process IDs. A fault in the size or permission bits appears as a wrong `rs_paddr` offset split or a wrong fault flag, in the cycle after the lookup that reads the entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_HIT    = 2'd1,
        RS_MISS   = 2'd2,
        RS_WFAULT = 2'd3
    } resp_state_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
    parameter int N       = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int PID_W   = 8,
    parameter int LG_BITS = 9,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [PID_W-1:0]  fl_pid,
    input  logic              fl_large,
    input  logic [PFN_W-1:0]  fl_pfn,
    input  logic              fl_wr,
    input  logic [VPN_W-1:0]  iv_vpn,
    input  logic [PID_W-1:0]  iv_pid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              clr_inv,
    input  logic              clr_all,
    output logic [N-1:0]      valid_o,
    output logic [N-1:0]      fl_ovl_o,
    output logic              lk_any_o,
    output logic [PFN_W-1:0]  lk_pfn_o,
    output logic              lk_large_o,
    output logic              lk_wr_o
);
    logic [N-1:0]     e_valid;
    logic [PID_W-1:0] e_pid   [N];
    logic [VPN_W-1:0] e_vpn   [N];
    logic [PFN_W-1:0] e_pfn   [N];
    logic [N-1:0]     e_large;
    logic [N-1:0]     e_wr;

    logic [N-1:0] lk_match;
    logic [N-1:0] iv_match;
    logic [N-1:0] fl_match;

    function automatic logic page_match(
        input logic             v,
        input logic [PID_W-1:0] ep,
        input logic [VPN_W-1:0] ev,
        input logic             el,
        input logic [PID_W-1:0] p,
        input logic [VPN_W-1:0] q,
        input logic             wide
    );
        logic up_eq;
        logic lo_eq;
        up_eq = (ev[VPN_W-1:LG_BITS] == q[VPN_W-1:LG_BITS]);
        lo_eq = (ev[LG_BITS-1:0] == q[LG_BITS-1:0]);
        return v && (ep == p) && up_eq && (el || wide || lo_eq);
    endfunction

    // one comparator set per entry, all evaluated in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign lk_match[g] = page_match(e_valid[g], e_pid[g], e_vpn[g], e_large[g],
                                        lk_pid, lk_vpn, 1'b0);
        assign iv_match[g] = page_match(e_valid[g], e_pid[g], e_vpn[g], e_large[g],
                                        iv_pid, iv_vpn, 1'b0);
        assign fl_match[g] = page_match(e_valid[g], e_pid[g], e_vpn[g], e_large[g],
                                        fl_pid, fl_vpn, fl_large);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_valid <= '0;
            e_large <= '0;
            e_wr    <= '0;
            for (int i = 0; i < N; i++) begin
                e_pid[i] <= '0;
                e_vpn[i] <= '0;
                e_pfn[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (clr_all) begin
                    e_valid[i] <= 1'b0;
                end else if (clr_inv) begin
                    if (iv_match[i]) e_valid[i] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    e_valid[i] <= 1'b1;
                    e_pid[i]   <= fl_pid;
                    e_vpn[i]   <= fl_vpn;
                    e_pfn[i]   <= fl_pfn;
                    e_large[i] <= fl_large;
                    e_wr[i]    <= fl_wr;
                end else if (wr_en && fl_match[i]) begin
                    e_valid[i] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        lk_pfn_o   = '0;
        lk_large_o = 1'b0;
        lk_wr_o    = 1'b0;
        for (int i = 0; i < N; i++) begin
            lk_pfn_o   = lk_pfn_o | ({PFN_W{lk_match[i]}} & e_pfn[i]);
            lk_large_o = lk_large_o | (lk_match[i] & e_large[i]);
            lk_wr_o    = lk_wr_o | (lk_match[i] & e_wr[i]);
        end
    end

    assign lk_any_o = |lk_match;
    assign valid_o  = e_valid;
    assign fl_ovl_o = fl_match;

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_o == '0)); // R9
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R7
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all && !clr_inv) |=> valid_o[$past(wr_idx)]); // R7
    AST_PURGE_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_inv |=> ((valid_o & $past(iv_match)) == '0)); // R8
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
    parameter int N      = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     ovl,
    input  logic             fill_en,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] ovl_idx;
    logic [IDX_W-1:0] free_idx;
    logic             use_rr;

    always_comb begin
        ovl_idx  = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (ovl[i])   ovl_idx  = IDX_W'(i);
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign use_rr = !(|ovl) && (&valid);

    always_comb begin
        if (|ovl)        idx_o = ovl_idx;
        else if (!use_rr) idx_o = free_idx;
        else             idx_o = rr_ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (fill_en && use_rr) begin
            rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rr_ptr) < N); // R7
    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> $stable(rr_ptr)); // R7
endmodule

// File: rtl/tlb_resp_fsm.sv
module tlb_resp_fsm
    import tlb_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            hit,
    input  logic            writable,
    input  logic            store,
    input  logic [PA_W-1:0] paddr_in,
    output logic            hit_o,
    output logic            miss_o,
    output logic            wfault_o,
    output logic [PA_W-1:0] paddr_o
);
    resp_state_e state;
    resp_state_e state_nxt;
    logic [PA_W-1:0] pa_q;

    always_comb begin
        if (!req)                     state_nxt = RS_IDLE;
        else if (!hit)                state_nxt = RS_MISS;
        else if (store && !writable)  state_nxt = RS_WFAULT;
        else                          state_nxt = RS_HIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            pa_q  <= '0;
        end else begin
            state <= state_nxt;
            pa_q  <= (state_nxt == RS_HIT) ? paddr_in : '0;
        end
    end

    always_comb begin
        hit_o    = 1'b0;
        miss_o   = 1'b0;
        wfault_o = 1'b0;
        paddr_o  = '0;
        unique case (state)
            RS_IDLE:   ;
            RS_HIT: begin
                hit_o   = 1'b1;
                paddr_o = pa_q;
            end
            RS_MISS:   miss_o   = 1'b1;
            RS_WFAULT: wfault_o = 1'b1;
            default:   ;
        endcase
    end

    AST_FAULT_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wfault_o |-> $past(store)); // R6
    AST_PA_ZERO_OFF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (paddr_o == '0)); // R4
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb #(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int PID_W       = 8,
    parameter int ENTRIES     = 8,
    parameter int PAGE_SHIFT  = 12,
    parameter int LARGE_SHIFT = 21,
    localparam int VPN_W      = VA_W - PAGE_SHIFT,
    localparam int PFN_W      = PA_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic              lk_store,
    output logic              rs_hit,
    output logic              rs_miss,
    output logic              rs_wfault,
    output logic [PA_W-1:0]   rs_paddr,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PID_W-1:0]  fill_pid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_large,
    input  logic              fill_writable,
    input  logic              inv_one,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [PID_W-1:0]  inv_pid,
    input  logic              inv_all
);
    localparam int LG_BITS = LARGE_SHIFT - PAGE_SHIFT;
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PA_W-1:0] SMALL_MASK = PA_W'((64'd1 << PAGE_SHIFT) - 64'd1);
    localparam logic [PA_W-1:0] LARGE_MASK = PA_W'((64'd1 << LARGE_SHIFT) - 64'd1);

    logic [ENTRIES-1:0] valid;
    logic [ENTRIES-1:0] fl_ovl;
    logic               lk_any;
    logic [PFN_W-1:0]   lk_pfn;
    logic               lk_large;
    logic               lk_wr;
    logic [IDX_W-1:0]   wr_idx;
    logic               clr_inv;
    logic               wr_en;
    logic [PA_W-1:0]    frame_base;
    logic [PA_W-1:0]    va_low;
    logic [PA_W-1:0]    pa_next;

    // update priority: flush-all, then single purge, then refill
    assign clr_inv = inv_one && !inv_all;
    assign wr_en   = fill_valid && !inv_all && !inv_one;

    tlb_entry_array #(
        .N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W), .LG_BITS(LG_BITS)
    ) i_array (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vaddr[VA_W-1:PAGE_SHIFT]), .lk_pid(lk_pid),
        .fl_vpn(fill_vpn), .fl_pid(fill_pid), .fl_large(fill_large),
        .fl_pfn(fill_pfn), .fl_wr(fill_writable),
        .iv_vpn(inv_vpn), .iv_pid(inv_pid),
        .wr_en(wr_en), .wr_idx(wr_idx), .clr_inv(clr_inv), .clr_all(inv_all),
        .valid_o(valid), .fl_ovl_o(fl_ovl), .lk_any_o(lk_any),
        .lk_pfn_o(lk_pfn), .lk_large_o(lk_large), .lk_wr_o(lk_wr)
    );

    tlb_victim_sel #(.N(ENTRIES)) i_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid), .ovl(fl_ovl),
        .fill_en(wr_en), .idx_o(wr_idx)
    );

    assign frame_base = {lk_pfn, {PAGE_SHIFT{1'b0}}};
    assign va_low     = PA_W'(lk_vaddr[LARGE_SHIFT-1:0]);
    assign pa_next    = lk_large ? ((frame_base & ~LARGE_MASK) | (va_low & LARGE_MASK))
                                 : ((frame_base & ~SMALL_MASK) | (va_low & SMALL_MASK));

    tlb_resp_fsm #(.PA_W(PA_W)) i_resp (
        .clk(clk), .rst_n(rst_n), .req(lk_valid), .hit(lk_any),
        .writable(lk_wr), .store(lk_store), .paddr_in(pa_next),
        .hit_o(rs_hit), .miss_o(rs_miss), .wfault_o(rs_wfault), .paddr_o(rs_paddr)
    );

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rs_hit, rs_miss, rs_wfault})); // R2
    AST_REQ_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rs_hit || rs_miss || rs_wfault)); // R2
    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(rs_hit || rs_miss || rs_wfault)); // R2
    AST_FLUSH_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all ##1 lk_valid |=> rs_miss); // R9
endmodule

// File: tb/test_tagged_tlb.sv
module test_tagged_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0;
    logic        lk_store = 1'b0;
    logic        rs_hit, rs_miss, rs_wfault;
    logic [31:0] rs_paddr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_pid = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_large = 1'b0;
    logic        fill_writable = 1'b0;
    logic        inv_one = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic [7:0]  inv_pid = '0;
    logic        inv_all = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    string tag = "R1";

    // reference model of the buffer
    bit        m_v  [N];
    bit [7:0]  m_pid[N];
    bit [19:0] m_vpn[N];
    bit [19:0] m_pfn[N];
    bit        m_lg [N];
    bit        m_wr [N];
    int        m_ptr = 0;

    // expected response for the cycle after the last applied inputs
    bit        e_hit = 0, e_miss = 0, e_wf = 0;
    bit [31:0] e_pa = '0;
    string     e_tag = "R1";

    // driven values for the next cycle
    bit        d_lk, d_st, d_fill, d_lg, d_wr, d_io, d_ia;
    bit [31:0] d_va;
    bit [7:0]  d_pid, d_fpid, d_ipid;
    bit [19:0] d_fvpn, d_fpfn, d_ivpn;

    tagged_tlb i_tagged_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_store(lk_store),
        .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_wfault(rs_wfault), .rs_paddr(rs_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_pfn(fill_pfn), .fill_large(fill_large), .fill_writable(fill_writable),
        .inv_one(inv_one), .inv_vpn(inv_vpn), .inv_pid(inv_pid), .inv_all(inv_all)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit covers(int i, bit [7:0] p, bit [19:0] q);
        return m_v[i] && m_pid[i] == p && m_vpn[i][19:9] == q[19:9] &&
               (m_lg[i] || m_vpn[i][8:0] == q[8:0]);
    endfunction

    function automatic bit overlaps(int i, bit [7:0] p, bit [19:0] q, bit lg);
        return m_v[i] && m_pid[i] == p && m_vpn[i][19:9] == q[19:9] &&
               (m_lg[i] || lg || m_vpn[i][8:0] == q[8:0]);
    endfunction

    task automatic idle_inputs();
        d_lk = 0; d_st = 0; d_fill = 0; d_lg = 0; d_wr = 0; d_io = 0; d_ia = 0;
        d_va = '0; d_pid = '0; d_fpid = '0; d_ipid = '0;
        d_fvpn = '0; d_fpfn = '0; d_ivpn = '0;
    endtask

    task automatic check_out();
        checks++;
        if (rs_hit !== e_hit || rs_miss !== e_miss || rs_wfault !== e_wf || rs_paddr !== e_pa) begin
            errors++;
            $display("FAIL %s: got hit=%0b miss=%0b wf=%0b pa=%h expected hit=%0b miss=%0b wf=%0b pa=%h",
                     e_tag, rs_hit, rs_miss, rs_wfault, rs_paddr, e_hit, e_miss, e_wf, e_pa);
        end
    endtask

    // one clock: check previous result, predict this one, update the model, drive
    task automatic tick();
        int found;
        @(negedge clk);
        check_out();
        e_tag = tag;
        e_hit = 0; e_miss = 0; e_wf = 0; e_pa = '0;
        if (d_lk) begin
            found = -1;
            for (int i = 0; i < N; i++) if (found < 0 && covers(i, d_pid, d_va[31:12])) found = i;
            if (found < 0) e_miss = 1;
            else if (d_st && !m_wr[found]) e_wf = 1;
            else begin
                e_hit = 1;
                e_pa = m_lg[found] ? {m_pfn[found][19:9], d_va[20:0]} : {m_pfn[found], d_va[11:0]};
            end
        end
        if (d_ia) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (d_io) begin
            for (int i = 0; i < N; i++) if (covers(i, d_ipid, d_ivpn)) m_v[i] = 0;
        end else if (d_fill) begin
            int slot;
            slot = -1;
            for (int i = 0; i < N; i++) if (slot < 0 && overlaps(i, d_fpid, d_fvpn, d_lg)) slot = i;
            for (int i = 0; i < N; i++) if (slot < 0 && !m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            for (int i = 0; i < N; i++) if (overlaps(i, d_fpid, d_fvpn, d_lg)) m_v[i] = 0;
            m_v[slot] = 1; m_pid[slot] = d_fpid; m_vpn[slot] = d_fvpn;
            m_pfn[slot] = d_fpfn; m_lg[slot] = d_lg; m_wr[slot] = d_wr;
        end
        lk_valid = d_lk; lk_vaddr = d_va; lk_pid = d_pid; lk_store = d_st;
        fill_valid = d_fill; fill_vpn = d_fvpn; fill_pid = d_fpid; fill_pfn = d_fpfn;
        fill_large = d_lg; fill_writable = d_wr;
        inv_one = d_io; inv_vpn = d_ivpn; inv_pid = d_ipid; inv_all = d_ia;
        idle_inputs();
    endtask

    task automatic look(bit [31:0] va, bit [7:0] p, bit st);
        d_lk = 1; d_va = va; d_pid = p; d_st = st;
        tick();
    endtask

    task automatic refill(bit [19:0] vpn, bit [7:0] p, bit [19:0] pfn, bit lg, bit wr);
        d_fill = 1; d_fvpn = vpn; d_fpid = p; d_fpfn = pfn; d_lg = lg; d_wr = wr;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got no end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        idle_inputs();
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        tag = "R1";
        tick();                     // checks the reset state
        rst_n = 1'b1;
        tick();
        look(32'h0040_3abc, 8'd1, 0);   // R1: first lookup misses

        tag = "R4";
        refill(20'h00403, 8'd1, 20'h12345, 0, 0);
        look(32'h0040_3abc, 8'd1, 0);
        tag = "R3";
        look(32'h0040_3abc, 8'd2, 0);
        tag = "R6";
        look(32'h0040_3123, 8'd1, 1);
        tag = "R2";
        tick();

        tag = "R5";
        refill(20'h00600, 8'd1, 20'h00A05, 1, 1);
        look(32'h0067_8123, 8'd1, 0);
        look(32'h007F_FFFF, 8'd1, 0);
        look(32'h0080_0000, 8'd1, 0);
        tag = "R6";
        look(32'h0061_0000, 8'd1, 1);

        tag = "R8";
        d_io = 1; d_ivpn = 20'h00610; d_ipid = 8'd1; tick();
        look(32'h0060_0000, 8'd1, 0);
        look(32'h0040_3000, 8'd1, 0);

        tag = "R9";
        d_ia = 1; tick();
        look(32'h0040_3000, 8'd1, 0);

        tag = "R7";
        for (int k = 0; k < 9; k++) refill(20'(32'h100 + k), 8'd3, 20'(32'h200 + k), 0, 1);
        look(32'h0010_0000, 8'd3, 0);
        look(32'h0010_8000, 8'd3, 0);
        look(32'h0010_1000, 8'd3, 0);
        refill(20'h00100, 8'd3, 20'h00777, 1, 1);   // large refill absorbs the small ones
        look(32'h0010_5000, 8'd3, 0);
        look(32'h0010_2abc, 8'd3, 1);

        tag = "R10";
        d_ia = 1; d_fill = 1; d_fvpn = 20'h00999; d_fpid = 8'd4; d_fpfn = 20'h11111; tick();
        look(32'h0099_9000, 8'd4, 0);
        refill(20'h00AAA, 8'd4, 20'h22222, 0, 1);
        d_io = 1; d_ivpn = 20'h00AAA; d_ipid = 8'd4;
        d_fill = 1; d_fvpn = 20'h00BBB; d_fpid = 8'd4; d_fpfn = 20'h33333; tick();
        look(32'h00AA_A000, 8'd4, 0);
        look(32'h00BB_B000, 8'd4, 0);

        tag = "R2/R3 random";
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit [31:0] va;
            r = int'($urandom % 100);
            va = (32'($urandom % 4) << 21) | (32'($urandom % 4) << 12) | 32'($urandom & 32'hFFF);
            if (r < 60) begin
                d_lk = 1; d_va = va; d_pid = 8'($urandom % 3); d_st = ($urandom % 10) < 4;
            end
            if (r >= 55 && r < 85) begin
                d_fill = 1; d_fvpn = va[31:12]; d_fpid = 8'($urandom % 3);
                d_fpfn = 20'($urandom); d_lg = ($urandom % 10) < 3; d_wr = $urandom % 2;
            end
            if (r >= 85 && r < 95) begin
                d_io = 1; d_ivpn = va[31:12]; d_ipid = 8'($urandom % 3);
            end
            if (r == 99) d_ia = 1;
            tick();
        end
        tick();
        tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule